// File: doc/BRIEF.md
# Variable-Width Pseudo-Random Sequence Generator

This block produces pseudo-random numbers from a linear feedback shift register whose length is chosen at run time, anywhere from 4 to 11 bits. A consumer programs a limit word; the leading one of that word sets how many bits the random value carries. For each width the block applies its own maximal-length feedback, so every width walks through all of its non-zero codes before it repeats.

The sequence moves forward by exactly one step for every read strobe. The value on the output is the one a read consumes, and the next value appears one cycle after the strobe. The limit only picks the width, so a returned value can be larger than the limit. Rejecting such values and reading again is the consumer's job.

When the width changes, the state is cut down to the new width and never left at zero. Because of that, switching widths in the middle of a sequence cannot lock the register.

Top module: `vw_lfsr_rng`

## Requirements
- R1: The active width equals one plus the bit index of the highest set bit of `limit_i`, bounded below by 4 and above by 11.
- R2: Any `limit_i` below 16, zero included, selects width 4, so that outputs lie in 1..15.
- R3: Any `limit_i` of 2048 or more selects width 11.
- R4: `rand_o` is always non-zero, and every bit at or above the active width reads 0.
- R5: A cycle with `read_i` high advances the state by one step, visible on `rand_o` after the next rising edge. With `read_i` low and the width unchanged, `rand_o` holds.
- R6: At a fixed width w, 2^w-1 consecutive reads visit each non-zero w-bit code once and then return to the starting value.
- R7: One step at width w computes fb = XOR of the state bits at the tap positions, then new state = {state[w-2:0], fb}. Tap bit positions for each width: 4:{3,2}, 5:{4,2}, 6:{5,4}, 7:{6,5}, 8:{7,5,4,3}, 9:{8,4}, 10:{9,6}, 11:{10,8}.
- R8: After reset the width is 4 and `rand_o` is 1.
- R9: When the width selected by `limit_i` differs from the registered width, the state is ANDed with the new width mask on the next edge. If the result is zero, the state becomes 1.
- R10: When a width change and a read fall in the same cycle, the state is first masked (and forced to 1 if zero), then stepped once with the new width's taps.
- R11: The limit only selects the width, so values above `limit_i` occur. For example, with `limit_i` = 20, outputs up to 31 appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| limit_i | input | 16 | Limit word; its leading one selects the width |
| read_i | input | 1 | Read strobe; one step per high cycle |
| rand_o | output | 11 | Current random value, zero-extended |

## Verification
A width change and a read can land on the same clock edge. In that case the block has to apply the new width's mask, and the zero fix-up if needed, before it steps with the new taps. The bench provokes this by changing `limit_i` in the very cycle `read_i` is high, once shrinking and once growing the width. A reference model that applies mask-then-step judges the value that appears after the edge. The zero fix-up is exercised separately by reading at 11 bits until the low nibble is zero and then dropping to width 4.

// File: rtl/vw_lfsr_pkg.sv
package vw_lfsr_pkg;
  localparam int unsigned TAP_TBL_W = 11;

  // maximal-length feedback taps, bit positions within the state
  function automatic logic [TAP_TBL_W-1:0] tap_mask(input int unsigned w);
    logic [TAP_TBL_W-1:0] m;
    m = '0;
    case (w)
      4:       m = 11'h00C;
      5:       m = 11'h014;
      6:       m = 11'h030;
      7:       m = 11'h060;
      8:       m = 11'h0B8;
      9:       m = 11'h110;
      10:      m = 11'h240;
      11:      m = 11'h500;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vw_lfsr_width_sel.sv
module vw_lfsr_width_sel #(
  parameter int unsigned LIM_W = 16,
  parameter int unsigned MIN_W = 4,
  parameter int unsigned MAX_W = 11,
  parameter int unsigned WID_W = 4
) (
  input  logic [LIM_W-1:0] limit_i,
  output logic [WID_W-1:0] width_o
);
  localparam int unsigned RAW_W = $clog2(LIM_W + 1);

  logic [RAW_W-1:0] raw;

  // leading-one position plus one
  always_comb begin
    raw = '0;
    for (int k = 0; k < LIM_W; k++) begin
      if (limit_i[k]) raw = RAW_W'(k + 1);
    end
  end

  always_comb begin
    if (raw < RAW_W'(MIN_W))      width_o = WID_W'(MIN_W);
    else if (raw > RAW_W'(MAX_W)) width_o = WID_W'(MAX_W);
    else                          width_o = WID_W'(raw);
  end
endmodule

// File: rtl/vw_lfsr_taps.sv
module vw_lfsr_taps #(
  parameter int unsigned MIN_W = 4,
  parameter int unsigned MAX_W = 11,
  parameter int unsigned WID_W = 4
) (
  input  logic [WID_W-1:0] width_i,
  output logic [MAX_W-1:0] taps_o,
  output logic [MAX_W-1:0] mask_o
);
  logic [MAX_W-1:0] tap_tbl [MIN_W:MAX_W];
  logic [MAX_W-1:0] msk_tbl [MIN_W:MAX_W];

  for (genvar g = MIN_W; g <= MAX_W; g++) begin : g_tbl
    localparam logic [vw_lfsr_pkg::TAP_TBL_W-1:0] FULL = vw_lfsr_pkg::tap_mask(g);
    assign tap_tbl[g] = FULL[MAX_W-1:0];
    assign msk_tbl[g] = {MAX_W{1'b1}} >> (MAX_W - g);
  end

  always_comb begin
    taps_o = '0;
    mask_o = {MAX_W{1'b1}} >> (MAX_W - MIN_W);
    for (int w = MIN_W; w <= MAX_W; w++) begin
      if (width_i == WID_W'(w)) begin
        taps_o = tap_tbl[w];
        mask_o = msk_tbl[w];
      end
    end
  end
endmodule

// File: rtl/vw_lfsr_core.sv
module vw_lfsr_core #(
  parameter int unsigned MIN_W = 4,
  parameter int unsigned MAX_W = 11,
  parameter int unsigned WID_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_i,
  input  logic [WID_W-1:0] width_i,
  input  logic [MAX_W-1:0] taps_i,
  input  logic [MAX_W-1:0] mask_i,
  output logic [MAX_W-1:0] state_o
);
  logic [MAX_W-1:0] st_q, st_d, kept, base, stepped, mask_q;
  logic [WID_W-1:0] wid_q;
  logic             wid_chg, fb;

  always_comb begin
    wid_chg = (width_i != wid_q);
    kept    = st_q & mask_i;
    if (kept == '0) kept = MAX_W'(1);   // never lock at zero
    base    = wid_chg ? kept : st_q;
    fb      = ^(base & taps_i);
    stepped = {base[MAX_W-2:0], fb} & mask_i;
    st_d    = read_i ? stepped : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MAX_W'(1);
      wid_q <= WID_W'(MIN_W);
    end else begin
      st_q  <= st_d;
      wid_q <= width_i;
    end
  end

  assign state_o = st_q;

  always_comb begin
    for (int b = 0; b < MAX_W; b++) mask_q[b] = (int'(wid_q) > b);
  end

  p_state_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
  p_state_in_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q & ~mask_q) == '0);
  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!read_i && !wid_chg) |=> $stable(st_q));
  p_step_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !wid_chg) |=> (st_q != $past(st_q)));
  p_wchg_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_chg && !read_i && ((st_q & mask_i) == '0)) |=> (st_q == MAX_W'(1)));
  p_wchg_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_chg && !read_i && ((st_q & mask_i) != '0)) |=> (st_q == $past(st_q & mask_i)));
endmodule

// File: rtl/vw_lfsr_rng.sv
module vw_lfsr_rng #(
  parameter int unsigned LIM_W = 16,
  parameter int unsigned MIN_W = 4,
  parameter int unsigned MAX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             read_i,
  output logic [MAX_W-1:0] rand_o
);
  localparam int unsigned WID_W = $clog2(MAX_W + 1);

  logic [WID_W-1:0] width;
  logic [MAX_W-1:0] taps, mask;

  vw_lfsr_width_sel #(.LIM_W(LIM_W), .MIN_W(MIN_W), .MAX_W(MAX_W), .WID_W(WID_W)) u_wsel (
    .limit_i (limit_i),
    .width_o (width)
  );

  vw_lfsr_taps #(.MIN_W(MIN_W), .MAX_W(MAX_W), .WID_W(WID_W)) u_taps (
    .width_i (width),
    .taps_o  (taps),
    .mask_o  (mask)
  );

  vw_lfsr_core #(.MIN_W(MIN_W), .MAX_W(MAX_W), .WID_W(WID_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .read_i  (read_i),
    .width_i (width),
    .taps_i  (taps),
    .mask_i  (mask),
    .state_o (rand_o)
  );

  p_width_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width >= WID_W'(MIN_W)) && (width <= WID_W'(MAX_W)));
  p_small_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((limit_i >> MIN_W) == '0) |-> (width == WID_W'(MIN_W)));
  p_big_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((limit_i >> MAX_W) != '0) |-> (width == WID_W'(MAX_W)));
  p_reset_seed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rand_o == MAX_W'(1)));
endmodule

// File: tb/vw_lfsr_rng_tb_top.sv
module vw_lfsr_rng_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] limit = '0;
  logic        rd = 1'b0;
  logic [10:0] rand_v;

  int n_chk = 0;
  int n_err = 0;

  logic [10:0] eq[$];
  int          wq[$];
  string       tq[$];

  logic [10:0] m_st = 11'd1;
  int          m_w  = 4;

  logic seen [0:2047];
  int   nseen = 0;
  bit   over20 = 1'b0;
  bit   finished = 1'b0;

  logic [10:0] mon_e;
  int          mon_w;
  string       mon_t;

  always #10 clk = ~clk;   // 20-unit period, 50 MHz

  vw_lfsr_rng dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .limit_i (limit),
    .read_i  (rd),
    .rand_o  (rand_v)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic int wid_of(input logic [15:0] l);
    int n = -1;
    int w;
    for (int k = 0; k < 16; k++) if (l[k]) n = k;
    w = n + 1;
    if (w < 4) w = 4;
    if (w > 11) w = 11;
    return w;
  endfunction

  function automatic logic fb_of(input logic [10:0] s, input int w);
    int e2;
    case (w)
      4: e2 = 3;  5: e2 = 3;  6: e2 = 5;  7: e2 = 6;
      9: e2 = 5;  10: e2 = 7; 11: e2 = 9; default: e2 = 0;
    endcase
    if (w == 8) return s[7] ^ s[5] ^ s[4] ^ s[3];
    return s[w-1] ^ s[e2-1];
  endfunction

  task automatic model_apply(input logic [15:0] lim, input bit r);
    int          nw = wid_of(lim);
    logic [10:0] msk = 11'((1 << nw) - 1);
    logic [10:0] b = m_st;
    if (nw != m_w) begin
      b = m_st & msk;
      if (b == '0) b = 11'd1;
    end
    if (r) b = {b[9:0], fb_of(b, nw)} & msk;
    m_st = b;
    m_w  = nw;
  endtask

  task automatic drive(input logic [15:0] lim, input bit r, input string tag);
    @(negedge clk);
    limit = lim;
    rd    = r;
    model_apply(lim, r);
    eq.push_back(m_st);
    wq.push_back(m_w);
    tq.push_back(tag);
  endtask

  task automatic drain();
    while (eq.size() != 0) @(posedge clk);
    #6;
  endtask

  // monitor: compare each produced value with its expectation
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (eq.size() > 0) begin
        mon_e = eq.pop_front();
        mon_w = wq.pop_front();
        mon_t = tq.pop_front();
        chk(rand_v == mon_e, mon_t, int'(rand_v), int'(mon_e));
        chk((rand_v != '0) && ((rand_v >> mon_w) == '0), "R4", int'(rand_v), mon_w);
        if (mon_t == "R6") begin
          if (seen[rand_v]) chk(1'b0, "R6 repeat", int'(rand_v), 0);
          seen[rand_v] = 1'b1;
          nseen++;
        end
        if (mon_t == "R11" && rand_v > 11'd20) over20 = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [10:0] start;
    int guard;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rand_v == 11'd1, "R8 reset seed", int'(rand_v), 1);

    // R2: small limits stay 4-bit
    drive(16'd0, 1'b0, "R2");
    for (int i = 0; i < 9; i++) drive(16'd0, 1'b1, "R2");
    for (int i = 0; i < 9; i++) drive(16'd15, 1'b1, "R2");
    // R5: hold without read
    for (int i = 0; i < 3; i++) drive(16'd15, 1'b0, "R5");

    // R1/R7: leading-one sweep
    for (int k = 4; k <= 10; k++) begin
      drive(16'(1) << k, 1'b0, "R1");
      for (int i = 0; i < 3; i++) drive((16'(1) << k) | 16'd3, 1'b1, "R7");
    end
    // R3: large limits clamp to 11 bits
    drive(16'hFFFF, 1'b1, "R3");
    drive(16'h0800, 1'b1, "R3");
    drive(16'h0800, 1'b0, "R3");
    drain();

    // R6: full period at each width
    for (int w = 4; w <= 11; w++) begin
      drive(16'(1) << (w - 1), 1'b0, "R6s");
      drain();
      for (int v = 0; v < 2048; v++) seen[v] = 1'b0;
      nseen = 0;
      start = m_st;
      for (int i = 0; i < (1 << w) - 1; i++) drive(16'(1) << (w - 1), 1'b1, "R6");
      drive(16'(1) << (w - 1), 1'b0, "R6s");
      drain();
      chk(nseen == (1 << w) - 1, "R6 count", nseen, (1 << w) - 1);
      chk(rand_v == start, "R6 wrap", int'(rand_v), int'(start));
    end

    // R9: masked-to-zero forces 1
    drive(16'h0800, 1'b0, "R9");
    guard = 0;
    while ((m_st[3:0] != 4'd0) && guard < 3000) begin
      drive(16'h0800, 1'b1, "R7");
      guard++;
    end
    drive(16'h0005, 1'b0, "R9");
    drain();
    chk(rand_v == 11'd1, "R9 zero forced to 1", int'(rand_v), 1);
    // R9: non-zero masking on shrink
    drive(16'hFFFF, 1'b0, "R9");
    for (int i = 0; i < 12; i++) drive(16'hFFFF, 1'b1, "R7");
    drive(16'h00FF, 1'b0, "R9");
    drive(16'h00FF, 1'b0, "R5");

    // R10: width change together with read
    drive(16'h0040, 1'b1, "R10");
    drive(16'h0400, 1'b1, "R10");
    drive(16'h0003, 1'b1, "R10");
    drive(16'h0003, 1'b0, "R5");

    // R11: values above the limit occur
    drive(16'd20, 1'b0, "R11s");
    for (int i = 0; i < 31; i++) drive(16'd20, 1'b1, "R11");
    drive(16'd20, 1'b0, "R11s");
    drain();
    chk(over20, "R11 value above limit seen", int'(over20), 1);

    summary();
  end
endmodule